// File: doc/BRIEF.md
# Paged DRAM Controller With Byte Read-Modify-Write

This block sits between an 8-bit CPU, a DMA engine and a 16-bit-wide SIMM-style DRAM. Each request supplies 13 page-mapping bits and 11 word-offset bits, which form a 24-bit word address. The CPU's byte-select address bit never reaches the memory. The controller presents the address in two halves on ten shared address pins plus one extra high pin. It asserts one of four row strobes, chosen from the address, and drives a single column strobe shared by all banks.

CPU reads return a whole 16-bit word. A CPU byte write is done as an indivisible read-modify-write. The word is read into an internal register with a first column pulse. The byte selected by the CPU's low address bit is replaced, and the word is written back with a second column pulse. Refresh uses column-before-row strobing and relies on the memory's internal row counter. A programmable interval counter raises a refresh request and keeps it raised until it is serviced.

New requests and the DMA permit are examined only while the controller is idle. Once a sequence starts, it always runs to the end and then returns to idle. This is why the permit must be withdrawn early enough before a CPU strobe is due. The DMA port issues word reads only.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held and right after it, all four row strobes, the column strobe and the write enable are high (inactive), the data bus is not driven, and neither done output is high.
- R2: The word address is {page, offset}. The CPU offset is address bits 11..1; the DMA offset is its 11-bit address. In the row phase the ten address pins carry word bits 19..10. In the column phase they carry word bits 9..0.
- R3: Word bits 21..20 select which row strobe (index 0..3) goes low for an access. During an access exactly one row strobe is low.
- R4: The extra high address pin carries word bit 23 in the row phase and word bit 22 in the column phase.
- R5: A read returns the stored 16-bit word on rdWord while the requester's done output pulses for one cycle. CPU address bit 0 has no effect on a read.
- R6: A byte write uses exactly two column pulses. The second pulse has write enable low and the bus driven. CPU address bit 0 = 0 replaces bits 7..0 and bit 0 = 1 replaces bits 15..8. The other byte keeps its stored value.
- R7: The first column pulse of an access starts exactly three cycles after its row strobe falls. This leaves one idle cycle after the column address appears.
- R8: A refresh lowers the column strobe first. All four row strobes then fall together, with write enable high and the bus not driven.
- R9: Once all row strobes have returned high, at least two full cycles pass before any row strobe falls again.
- R10: Requests taken at idle are ranked: CPU first, then refresh, then DMA.
- R11: Refresh and DMA are started only when dmaOk is high. CPU requests are served regardless of dmaOk.
- R12: A sequence that has started completes, and its done pulse is produced, even if the request and dmaOk drop during it.
- R13: A refresh request is raised every REF_INTERVAL cycles and held until serviced. With no competing traffic, refreshes start exactly REF_INTERVAL cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuRdReq | input | 1 | CPU word-read request, held until cpuDone |
| cpuWrReq | input | 1 | CPU byte-write request, held until cpuDone |
| cpuAddr | input | 12 | CPU address; bit 0 selects the byte |
| cpuPage | input | 13 | Page-mapping bits for the CPU access |
| cpuWrData | input | 8 | Byte to write |
| dmaReq | input | 1 | DMA word-read request, held until dmaDone |
| dmaAddr | input | 11 | DMA word offset |
| dmaPage | input | 13 | Page-mapping bits for the DMA access |
| dmaOk | input | 1 | Permit for refresh and DMA to start |
| cpuDone | output | 1 | One-cycle completion pulse for a CPU request |
| dmaDone | output | 1 | One-cycle completion pulse for a DMA request |
| rdWord | output | 16 | Word read by the last access |
| dramAddr | output | 10 | Multiplexed row/column address pins |
| dramA11 | output | 1 | Extra high address pin, row and column halves |
| rasN | output | 4 | Active-low row strobes, one per bank |
| casN | output | 1 | Active-low shared column strobe |
| weN | output | 1 | Active-low write enable |
| dramDout | output | 16 | Data driven to the memory |
| dramDoe | output | 1 | Output enable for dramDout |
| dramDin | input | 16 | Data returned by the memory |

## Verification
A wrong sequencer state shows up at the strobes within the access in which it occurs. Examples are a missing gap cycle, a skipped read pulse before the write-back, a second row strobe, or a precharge that is too short. The cycle-counting properties flag it on the very cycle the offending strobe edge appears. Errors in the address or byte-merge datapath show at the pins in the row or column phase, or in rdWord on the done cycle of the next read of that word. A wrong arbitration or refresh-timer state shows as a misordered done pulse, or as a refresh interval that is off by some cycles, within one REF_INTERVAL.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_GAP, ST_CAS, ST_MERGE, ST_WRSET, ST_WRCAS,
    ST_REFCAS, ST_REFRAS, ST_REFEND, ST_PRE1, ST_PRE2
  } ctrlState_t;

  typedef enum logic [1:0] {
    OWN_NONE, OWN_CPU, OWN_DMA, OWN_REF
  } owner_t;

  // strobes from the sequencer to the address/data path
  typedef struct packed {
    logic capture;   // load address, byte select and write byte
    logic selDma;    // address source is the DMA port
    logic colPhase;  // column half on the address pins
    logic rasOne;    // decoded single row strobe
    logic rasAll;    // all row strobes (refresh)
    logic cas;       // column strobe
    logic we;        // write enable
    logic drive;     // drive the data bus
    logic latchRd;   // capture the read word
    logic merge;     // insert the CPU byte
  } ctrlStrobe_t;

endpackage

// File: rtl/dram_ctrl_fsm.sv
module dram_ctrl_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int REF_INTERVAL = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuRdReq,
  input  logic        cpuWrReq,
  input  logic        dmaReq,
  input  logic        dmaOk,
  output ctrlStrobe_t strobe,
  output logic        cpuDone,
  output logic        dmaDone
);

  localparam int REF_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_INTERVAL - 1);

  ctrlState_t state, nextState;
  owner_t     owner, nextOwner;
  logic       isWrite, nextWrite;
  logic       takeRef;
  logic       refPending;
  logic       refWrap;
  logic [REF_W-1:0] refCnt;

  // refresh interval timer: free running, request held until taken
  assign refWrap = (refCnt == REF_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      refCnt     <= refWrap ? '0 : refCnt + 1'b1;
      refPending <= refWrap | (refPending & ~takeRef);
    end
  end

  // sequencer: requests and permit looked at only in ST_IDLE
  always_comb begin
    nextState = state;
    nextOwner = owner;
    nextWrite = isWrite;
    takeRef   = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (cpuRdReq || cpuWrReq) begin
          nextState      = ST_ROW;
          nextOwner      = OWN_CPU;
          nextWrite      = !cpuRdReq;
          strobe.capture = 1'b1;
        end else if (dmaOk && refPending) begin
          nextState = ST_REFCAS;
          nextOwner = OWN_REF;
          takeRef   = 1'b1;
        end else if (dmaOk && dmaReq) begin
          nextState      = ST_ROW;
          nextOwner      = OWN_DMA;
          nextWrite      = 1'b0;
          strobe.capture = 1'b1;
          strobe.selDma  = 1'b1;
        end
      end
      ST_ROW: begin
        strobe.rasOne = 1'b1;
        nextState     = ST_COL;
      end
      ST_COL: begin
        strobe.rasOne   = 1'b1;
        strobe.colPhase = 1'b1;
        nextState       = ST_GAP;
      end
      ST_GAP: begin
        strobe.rasOne   = 1'b1;
        strobe.colPhase = 1'b1;
        nextState       = ST_CAS;
      end
      ST_CAS: begin
        strobe.rasOne   = 1'b1;
        strobe.colPhase = 1'b1;
        strobe.cas      = 1'b1;
        strobe.latchRd  = 1'b1;
        nextState       = isWrite ? ST_MERGE : ST_PRE1;
      end
      ST_MERGE: begin
        strobe.rasOne   = 1'b1;
        strobe.colPhase = 1'b1;
        strobe.merge    = 1'b1;
        nextState       = ST_WRSET;
      end
      ST_WRSET: begin
        strobe.rasOne   = 1'b1;
        strobe.colPhase = 1'b1;
        strobe.we       = 1'b1;
        strobe.drive    = 1'b1;
        nextState       = ST_WRCAS;
      end
      ST_WRCAS: begin
        strobe.rasOne   = 1'b1;
        strobe.colPhase = 1'b1;
        strobe.we       = 1'b1;
        strobe.drive    = 1'b1;
        strobe.cas      = 1'b1;
        nextState       = ST_PRE1;
      end
      ST_REFCAS: begin
        strobe.cas = 1'b1;
        nextState  = ST_REFRAS;
      end
      ST_REFRAS: begin
        strobe.cas    = 1'b1;
        strobe.rasAll = 1'b1;
        nextState     = ST_REFEND;
      end
      ST_REFEND: begin
        strobe.rasAll = 1'b1;
        nextState     = ST_PRE1;
      end
      ST_PRE1: nextState = ST_PRE2;
      ST_PRE2: begin
        nextState = ST_IDLE;
        nextOwner = OWN_NONE;
      end
      default: begin
        nextState = ST_IDLE;
        nextOwner = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      owner   <= OWN_NONE;
      isWrite <= 1'b0;
    end else begin
      state   <= nextState;
      owner   <= nextOwner;
      isWrite <= nextWrite;
    end
  end

  assign cpuDone = (state == ST_PRE1) && (owner == OWN_CPU);
  assign dmaDone = (state == ST_PRE1) && (owner == OWN_DMA);

endmodule

// File: rtl/dram_datapath.sv
module dram_datapath
  import dram_ctrl_pkg::*;
#(
  parameter int PAGE_W = 13,
  parameter int OFS_W  = 11,
  parameter int ROW_W  = 10,
  parameter int BANKS  = 4,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [OFS_W:0]      cpuAddr,
  input  logic [PAGE_W-1:0]   cpuPage,
  input  logic [DATA_W/2-1:0] cpuWrData,
  input  logic [OFS_W-1:0]    dmaAddr,
  input  logic [PAGE_W-1:0]   dmaPage,
  input  logic [DATA_W-1:0]   dramDin,
  output logic [ROW_W-1:0]    dramAddr,
  output logic                dramA11,
  output logic [BANKS-1:0]    rasN,
  output logic                casN,
  output logic                weN,
  output logic [DATA_W-1:0]   dramDout,
  output logic                dramDoe,
  output logic [DATA_W-1:0]   rdWord
);

  localparam int WORD_W = PAGE_W + OFS_W;
  localparam int BANK_W = $clog2(BANKS);
  localparam int BYTE_W = DATA_W / 2;
  localparam int BANK_LO = 2 * ROW_W;

  logic [WORD_W-1:0] wordAddr;
  logic              byteHi;
  logic [BYTE_W-1:0] wrByte;
  logic [DATA_W-1:0] dataReg;
  logic [ROW_W-1:0]  rowBits, colBits;
  logic [BANK_W-1:0] bankSel;

  assign rowBits = wordAddr[BANK_LO-1:ROW_W];
  assign colBits = wordAddr[ROW_W-1:0];
  assign bankSel = wordAddr[BANK_LO +: BANK_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAddr <= '0;
      byteHi   <= 1'b0;
      wrByte   <= '0;
      dataReg  <= '0;
    end else begin
      if (strobe.capture) begin
        wordAddr <= strobe.selDma ? {dmaPage, dmaAddr} : {cpuPage, cpuAddr[OFS_W:1]};
        byteHi   <= cpuAddr[0];
        wrByte   <= cpuWrData;
      end
      if (strobe.latchRd) begin
        dataReg <= dramDin;
      end else if (strobe.merge) begin
        if (byteHi) dataReg[DATA_W-1:BYTE_W] <= wrByte;
        else        dataReg[BYTE_W-1:0]      <= wrByte;
      end
    end
  end

  // address pin multiplexing: high pin carries the top two word bits
  assign dramAddr = strobe.colPhase ? colBits : rowBits;
  assign dramA11  = strobe.colPhase ? wordAddr[WORD_W-2] : wordAddr[WORD_W-1];

  for (genvar b = 0; b < BANKS; b++) begin : g_ras
    assign rasN[b] = ~(strobe.rasAll | (strobe.rasOne && (bankSel == BANK_W'(b))));
  end

  assign casN     = ~strobe.cas;
  assign weN      = ~strobe.we;
  assign dramDoe  = strobe.drive;
  assign dramDout = dataReg;
  assign rdWord   = dataReg;

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int PAGE_W       = 13,
  parameter int OFS_W        = 11,
  parameter int ROW_W        = 10,
  parameter int BANKS        = 4,
  parameter int DATA_W       = 16,
  parameter int REF_INTERVAL = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuRdReq,
  input  logic                cpuWrReq,
  input  logic [OFS_W:0]      cpuAddr,
  input  logic [PAGE_W-1:0]   cpuPage,
  input  logic [DATA_W/2-1:0] cpuWrData,
  input  logic                dmaReq,
  input  logic [OFS_W-1:0]    dmaAddr,
  input  logic [PAGE_W-1:0]   dmaPage,
  input  logic                dmaOk,
  output logic                cpuDone,
  output logic                dmaDone,
  output logic [DATA_W-1:0]   rdWord,
  output logic [ROW_W-1:0]    dramAddr,
  output logic                dramA11,
  output logic [BANKS-1:0]    rasN,
  output logic                casN,
  output logic                weN,
  output logic [DATA_W-1:0]   dramDout,
  output logic                dramDoe,
  input  logic [DATA_W-1:0]   dramDin
);

  ctrlStrobe_t strobe;

  dram_ctrl_fsm #(
    .REF_INTERVAL(REF_INTERVAL)
  ) i_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .cpuRdReq(cpuRdReq),
    .cpuWrReq(cpuWrReq),
    .dmaReq  (dmaReq),
    .dmaOk   (dmaOk),
    .strobe  (strobe),
    .cpuDone (cpuDone),
    .dmaDone (dmaDone)
  );

  dram_datapath #(
    .PAGE_W(PAGE_W),
    .OFS_W (OFS_W),
    .ROW_W (ROW_W),
    .BANKS (BANKS),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cpuAddr  (cpuAddr),
    .cpuPage  (cpuPage),
    .cpuWrData(cpuWrData),
    .dmaAddr  (dmaAddr),
    .dmaPage  (dmaPage),
    .dramDin  (dramDin),
    .dramAddr (dramAddr),
    .dramA11  (dramA11),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .dramDout (dramDout),
    .dramDoe  (dramDoe),
    .rdWord   (rdWord)
  );

endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
  parameter int BANKS = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [BANKS-1:0] rasN,
  input logic             casN,
  input logic             weN,
  input logic             dramDoe,
  input logic             cpuDone,
  input logic             dmaDone
);

  logic [1:0] highCnt;   // cycles all row strobes high, saturating
  logic [2:0] lowCnt;    // cycles since a row strobe fell, saturating
  logic       casSeen;   // a column pulse already happened in this access

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt <= 2'd3;
      lowCnt  <= '0;
      casSeen <= 1'b0;
    end else if (rasN == '1) begin
      highCnt <= (highCnt == 2'd3) ? highCnt : highCnt + 1'b1;
      lowCnt  <= '0;
      casSeen <= 1'b0;
    end else begin
      highCnt <= '0;
      lowCnt  <= (lowCnt == 3'd7) ? lowCnt : lowCnt + 1'b1;
      casSeen <= casSeen | ~casN;
    end
  end

  p_one_bank_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(~rasN) == 0) || ($countones(~rasN) == 1) || ($countones(~rasN) == BANKS));

  p_gap_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && ($countones(~rasN) == 1) && !casSeen) |-> (lowCnt == 3'd3));

  p_write_second_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && !weN) |-> casSeen);

  p_write_drives_r6: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (dramDoe && ($countones(~rasN) == 1)));

  p_cas_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && (rasN == '1)) |=> (rasN == '0));

  p_refresh_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rasN == '0) |-> (weN && !dramDoe));

  p_precharge_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((rasN != '1) && ($past(rasN) == '1)) |-> (highCnt >= 2'd2));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cpuDone, dmaDone}));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone || dmaDone) |=> !(cpuDone || dmaDone));

endmodule

bind dram_page_ctrl dram_ctrl_chk i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .rasN   (rasN),
  .casN   (casN),
  .weN    (weN),
  .dramDoe(dramDoe),
  .cpuDone(cpuDone),
  .dmaDone(dmaDone)
);

// File: tb/test_dram_page_ctrl.sv
module test_dram_page_ctrl;

  localparam int REF_INT = 64;

  typedef struct packed {
    logic        isRead;
    logic [12:0] page;
    logic [11:0] addr;
    logic [7:0]  wdata;
    logic [15:0] expWord;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 13'h0001, 12'h004, 8'hA5, 16'h0000},
    '{1'b0, 13'h0001, 12'h005, 8'h3C, 16'h0000},
    '{1'b1, 13'h0001, 12'h004, 8'h00, 16'h3CA5},
    '{1'b0, 13'h1ABC, 12'hFFF, 8'h77, 16'h0000},
    '{1'b1, 13'h1ABC, 12'hFFE, 8'h00, 16'h7700},
    '{1'b0, 13'h1ABC, 12'hFFE, 8'h11, 16'h0000},
    '{1'b1, 13'h1ABC, 12'hFFF, 8'h00, 16'h7711},
    '{1'b0, 13'h0001, 12'h004, 8'h5A, 16'h0000},
    '{1'b1, 13'h0001, 12'h004, 8'h00, 16'h3C5A},
    '{1'b1, 13'h0800, 12'h000, 8'h00, 16'h0000},
    '{1'b0, 13'h0200, 12'h400, 8'hC3, 16'h0000},
    '{1'b1, 13'h0200, 12'h401, 8'h00, 16'h00C3},
    '{1'b0, 13'h0400, 12'h002, 8'h99, 16'h0000},
    '{1'b1, 13'h0400, 12'h003, 8'h00, 16'h0099}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuRdReq = 1'b0, cpuWrReq = 1'b0;
  logic [11:0] cpuAddr = '0;
  logic [12:0] cpuPage = '0;
  logic [7:0]  cpuWrData = '0;
  logic        dmaReq = 1'b0;
  logic [10:0] dmaAddr = '0;
  logic [12:0] dmaPage = '0;
  logic        dmaOk = 1'b0;
  logic        cpuDone, dmaDone;
  logic [15:0] rdWord;
  logic [9:0]  dramAddr;
  logic        dramA11;
  logic [3:0]  rasN;
  logic        casN, weN, dramDoe;
  logic [15:0] dramDout;
  logic [15:0] dinReg = '0;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_page_ctrl #(.REF_INTERVAL(REF_INT)) i_dram_page_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuRdReq(cpuRdReq), .cpuWrReq(cpuWrReq), .cpuAddr(cpuAddr),
    .cpuPage(cpuPage), .cpuWrData(cpuWrData),
    .dmaReq(dmaReq), .dmaAddr(dmaAddr), .dmaPage(dmaPage), .dmaOk(dmaOk),
    .cpuDone(cpuDone), .dmaDone(dmaDone), .rdWord(rdWord),
    .dramAddr(dramAddr), .dramA11(dramA11), .rasN(rasN), .casN(casN),
    .weN(weN), .dramDout(dramDout), .dramDoe(dramDoe), .dramDin(dinReg)
  );

  // behavioural memory, observed at the falling edge
  logic [15:0] mem [logic [23:0]];
  logic [3:0]  prevRasN = 4'hF;
  logic        prevCasN = 1'b1;
  logic [9:0]  mRow = '0, mCol = '0;
  logic [1:0]  mBank = '0;
  logic        mA11r = 1'b0, mA11c = 1'b0;
  int casPulses = 0, firstCas = 0, accStart = 0;
  int cbrCount = 0, cbrBad = 0, lastCbr = -1, prevCbr = -1;
  int highRun = 1000, minHigh = 1000;

  always @(negedge clk) begin
    logic [23:0] key;
    if (!rstN) begin
      prevRasN = 4'hF;
      prevCasN = 1'b1;
    end else begin
      if (prevRasN == 4'hF && rasN == 4'h0) begin
        if (!prevCasN && weN && !dramDoe) begin
          cbrCount++;
          prevCbr = lastCbr;
          lastCbr = cyc;
        end else cbrBad++;
      end else if (prevRasN == 4'hF && rasN != 4'hF) begin
        for (int b = 0; b < 4; b++) if (!rasN[b]) mBank = 2'(b);
        mRow = dramAddr;
        mA11r = dramA11;
        accStart = cyc;
        casPulses = 0;
      end
      if (prevRasN == 4'hF && rasN != 4'hF && highRun < minHigh) minHigh = highRun;
      highRun = (rasN == 4'hF) ? highRun + 1 : 0;
      if (!casN && prevCasN && rasN != 4'hF && rasN != 4'h0) begin
        if (casPulses == 0) begin
          firstCas = cyc - accStart;
          mCol = dramAddr;
          mA11c = dramA11;
        end
        casPulses++;
        key = {mA11r, mA11c, mBank, mRow, mCol};
        if (!weN) mem[key] = dramDout;
        else dinReg = mem.exists(key) ? mem[key] : 16'h0000;
      end
      prevRasN = rasN;
      prevCasN = casN;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpuOp(input logic isRead, input logic [12:0] page, input logic [11:0] addr,
                       input logic [7:0] wdata, output logic [15:0] got, output bit seen);
    @(negedge clk);
    cpuPage = page; cpuAddr = addr; cpuWrData = wdata;
    cpuRdReq = isRead; cpuWrReq = !isRead;
    seen = 0; got = '0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (cpuDone) begin seen = 1; got = rdWord; end
    end
    cpuRdReq = 0; cpuWrReq = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    bit seen;
    int t0, c0, dmaSeen;
    logic [23:0] w;

    repeat (3) @(negedge clk);
    // R1: idle levels during reset
    chk(rasN == 4'hF && casN && weN && !dramDoe && !cpuDone && !dmaDone, "R1 in reset",
        {rasN, casN, weN, dramDoe, cpuDone, dmaDone}, 32'h1F8);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(rasN == 4'hF && casN && weN && !dramDoe && !cpuDone && !dmaDone, "R1 after reset",
        {rasN, casN, weN, dramDoe, cpuDone, dmaDone}, 32'h1F8);

    // table walk with dmaOk low (R11: CPU served without permit)
    for (int v = 0; v < NVEC; v++) begin
      cpuOp(VEC[v].isRead, VEC[v].page, VEC[v].addr, VEC[v].wdata, got, seen);
      chk(seen, "R11 cpu served with dmaOk low", 32'(seen), 1);
      w = {VEC[v].page, VEC[v].addr[11:1]};
      chk({mRow, mCol} == w[19:0], "R2 row/column split", {mRow, mCol}, w[19:0]);
      chk(mBank == w[21:20], "R3 bank strobe", mBank, w[21:20]);
      chk({mA11r, mA11c} == w[23:22], "R4 high pin halves", {mA11r, mA11c}, w[23:22]);
      chk(firstCas == 3, "R7 gap before column pulse", firstCas, 3);
      if (VEC[v].isRead) begin
        chk(got == VEC[v].expWord, "R5 read word", got, VEC[v].expWord);
        chk(casPulses == 1, "R5 one column pulse", casPulses, 1);
      end else begin
        chk(casPulses == 2, "R6 two column pulses", casPulses, 2);
      end
    end

    // R11: no refresh or DMA without permit
    @(negedge clk);
    c0 = cbrCount;
    dmaPage = 13'h0001; dmaAddr = 11'h002; dmaReq = 1'b1;
    dmaSeen = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (dmaDone) dmaSeen++;
    end
    chk(dmaSeen == 0, "R11 dma held off", dmaSeen, 0);
    chk(cbrCount == c0, "R11 refresh held off", cbrCount, c0);

    // R13 held request, R10 refresh before DMA
    t0 = cyc;
    dmaOk = 1'b1;
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (dmaDone) begin seen = 1; got = rdWord; end
    end
    dmaReq = 1'b0;
    chk(seen, "R11 dma after permit", 32'(seen), 1);
    chk(cbrCount == c0 + 1, "R13 held refresh served", cbrCount, c0 + 1);
    chk(lastCbr >= t0 && lastCbr <= t0 + 3, "R13 held refresh prompt", lastCbr - t0, 2);
    chk(lastCbr < accStart, "R10 refresh before dma", lastCbr, accStart);
    chk(got == 16'h3C5A, "R5 dma read word", got, 16'h3C5A);

    // R13 interval, R8 column-first refresh
    repeat (150) @(negedge clk);
    chk(lastCbr - prevCbr == REF_INT, "R13 refresh interval", lastCbr - prevCbr, REF_INT);
    chk(cbrBad == 0, "R8 refresh strobe order", cbrBad, 0);

    // R10 CPU ahead of DMA
    @(negedge clk);
    dmaPage = 13'h1ABC; dmaAddr = 11'h7FF; dmaReq = 1'b1;
    cpuPage = 13'h0400; cpuAddr = 12'h002; cpuRdReq = 1'b1;
    seen = 0; dmaSeen = 0;
    for (int i = 0; i < 40 && !seen && dmaSeen == 0; i++) begin
      @(negedge clk);
      if (cpuDone) seen = 1;
      if (dmaDone) dmaSeen = 1;
    end
    cpuRdReq = 1'b0;
    chk(seen && dmaSeen == 0, "R10 cpu before dma", {seen, 1'(dmaSeen)}, 2);
    dmaSeen = 0;
    for (int i = 0; i < 40 && dmaSeen == 0; i++) begin
      @(negedge clk);
      if (dmaDone) begin dmaSeen = 1; got = rdWord; end
    end
    dmaReq = 1'b0;
    chk(got == 16'h7711, "R5 dma read after cpu", got, 16'h7711);

    // R12: drop request and permit once the access has begun
    @(negedge clk);
    dmaPage = 13'h0200; dmaAddr = 11'h200; dmaReq = 1'b1;
    for (int i = 0; i < 30 && $countones(~rasN) != 1; i++) @(negedge clk);
    dmaReq = 1'b0; dmaOk = 1'b0;
    dmaSeen = 0;
    for (int i = 0; i < 12 && dmaSeen == 0; i++) begin
      @(negedge clk);
      if (dmaDone) begin dmaSeen = 1; got = rdWord; end
    end
    chk(dmaSeen == 1, "R12 started access completes", dmaSeen, 1);
    chk(got == 16'h00C3 && casPulses == 1, "R12 completed read data", got, 16'h00C3);
    repeat (3) @(negedge clk);
    chk(rasN == 4'hF && casN, "R12 back to idle", {rasN, casN}, 5'h1F);

    // R9 minimum precharge over the whole run
    chk(minHigh >= 2, "R9 precharge", minHigh, 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule